// File: doc/BRIEF.md
# Tag-Matched Flushable Token Queue

This block is a small first-in first-out buffer that moves instruction tokens from one pipeline to another. Each slot holds a payload and a 4-bit tag naming the instruction the token belongs to. Tokens are pushed at the tail and read at the head. The head token is visible on the outputs before it is popped.

A flush broadcast can cut the queue short. The broadcast has a strobe, the tag of the oldest instruction to discard, and a flag that reports whether that instruction has already gone past the head. One cycle after the strobe, the queue searches for the tag. The search starts at the head and moves toward the tail. The first slot that matches is dropped, together with every slot behind it. Slots in front of the match are kept in their order.

If the flag is set, the whole queue is emptied instead. If no slot matches and the flag is clear, nothing changes. The producer guarantees that it sends no push or pop in the cycle the flush is applied, so the queue ignores both in that cycle.

Top module: `token_flush_queue`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `count`=0.
- R2: Tokens leave in the order they were pushed. `head_data` and `head_tag` show the oldest stored token. A pop removes it.
- R3: A push while `full`=1 is ignored. A pop while `empty`=1 is ignored.
- R4: `count` never exceeds DEPTH. `full` is high exactly when `count`=DEPTH. `empty` is high exactly when `count`=0.
- R5: A flush takes effect one cycle after `flush_req`. In the cycle the strobe is sampled, the contents change only through that cycle's push and pop.
- R6: A partial flush keeps the entries older than the first matching entry, in order. All other entries are removed, and `count` becomes the number of entries kept.
- R7: If no stored tag matches and `flush_past_head`=0, the flush changes neither the contents nor `count`.
- R8: If `flush_past_head`=1, the flush empties the queue whatever the tags are.
- R9: Push and pop are ignored in the cycle a flush is applied.
- R10: After a partial flush, the next push lands directly behind the last kept entry.
- R11: When several entries carry the flush tag, the one nearest the head decides the cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Write a token at the tail |
| push_data | input | DATA_W | Payload to write |
| push_tag | input | TAG_W | Tag of the token to write |
| pop | input | 1 | Remove the head token |
| head_data | output | DATA_W | Payload of the oldest token |
| head_tag | output | TAG_W | Tag of the oldest token |
| empty | output | 1 | No tokens stored |
| full | output | 1 | DEPTH tokens stored |
| count | output | CNT_W | Number of tokens stored |
| flush_req | input | 1 | Flush broadcast strobe |
| flush_tag | input | TAG_W | Tag of the oldest instruction to discard |
| flush_past_head | input | 1 | The flushed instruction has already left the queue, so clear everything |

## Verification
The bench builds the queue at its default parameters: depth 4, 8-bit payload, 4-bit tag. At this size every fill level from 0 to 4 can be combined with every head position around the ring, and with every possible match position plus the no-match and clear-all cases.

Each of these flushes is followed by a push and a full drain. This exposes the retained order and where the write pointer was restored, including positions where the kept region wraps past the end of the storage. Cases with repeated tags, overflow and underflow attempts, and push and pop during the flush cycle are added on top.

// File: rtl/token_flush_queue.sv
module token_flush_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [TAG_W-1:0]  head_tag,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  input  logic              flush_req,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic              flush_past_head
);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              fl_pend, fl_all_q;
  logic [TAG_W-1:0]  fl_tag_q;
  logic              hit;
  logic [CNT_W-1:0]  hit_idx;

  function automatic logic [PTR_W-1:0] ring(input logic [PTR_W-1:0] base, input int ofs);
    int s;
    s = int'(base) + ofs;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_data = data_q[rd_ptr];
  assign head_tag  = tag_q[rd_ptr];

  wire do_push = push && !full  && !fl_pend;
  wire do_pop  = pop  && !empty && !fl_pend;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < int'(cnt_q) && tag_q[ring(rd_ptr, i)] == fl_tag_q) begin
        hit     = 1'b1;
        hit_idx = CNT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      data_q[wr_ptr] <= push_data;
      tag_q[wr_ptr]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt_q    <= '0;
      fl_pend  <= 1'b0;
      fl_all_q <= 1'b0;
      fl_tag_q <= '0;
    end else begin
      fl_pend  <= flush_req;
      fl_tag_q <= flush_tag;
      fl_all_q <= flush_past_head;
      if (fl_pend) begin
        if (fl_all_q) begin
          cnt_q  <= '0;
          wr_ptr <= rd_ptr;
        end else if (hit) begin
          cnt_q  <= hit_idx;
          wr_ptr <= ring(rd_ptr, int'(hit_idx));
        end
      end else begin
        if (do_push) wr_ptr <= ring(wr_ptr, 1);
        if (do_pop)  rd_ptr <= ring(rd_ptr, 1);
        cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
    end
  end

endmodule

// File: rtl/token_flush_queue_chk.sv
module token_flush_queue_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic             empty,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             flush_req,
  input logic             fl_pend,
  input logic             fl_all_q
);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full}));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !fl_pend |=> full);

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty);

  p_req_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !fl_pend && !push && !pop |=> count == $past(count));

  p_apply_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pend |=> count <= $past(count));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pend && fl_all_q |=> empty);

endmodule

bind token_flush_queue token_flush_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .empty(empty), .full(full),
  .count(count), .flush_req(flush_req), .fl_pend(fl_pend), .fl_all_q(fl_all_q));

// File: tb/test_token_flush_queue.sv
`timescale 1ns/1ps
module test_token_flush_queue;
  localparam int DEPTH = 4;
  localparam int CNT_W = 3;

  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, flush_req = 0, flush_past_head = 0;
  logic [7:0] push_data = 0;
  logic [3:0] push_tag = 0, flush_tag = 0;
  logic [7:0] head_data;
  logic [3:0] head_tag;
  logic empty, full;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  int serial = 0;
  logic [7:0] ed [8];
  logic [3:0] et [8];
  int en = 0;

  always #4 clk = ~clk;

  token_flush_queue i_token_flush_queue (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [3:0] t);
    @(negedge clk);
    push = 1; push_tag = t; push_data = 8'(serial);
    if (en < 8) begin ed[en] = 8'(serial); et[en] = t; en++; end
    serial++;
    @(negedge clk);
    push = 0;
  endtask

  task automatic do_pop_only();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic flush(input logic [3:0] t, input logic all, input int cnt_before);
    @(negedge clk);
    flush_req = 1; flush_tag = t; flush_past_head = all;
    @(negedge clk);
    flush_req = 0; flush_past_head = 0;
    chk("R5 count held before flush applies", int'(count), cnt_before);
    push = 1; pop = 1; push_data = 8'hEE; push_tag = 4'hE;  // R9 ignored in apply cycle
    @(negedge clk);
    push = 0; pop = 0;
  endtask

  task automatic drain(input string req);
    int n = en;
    for (int i = 0; i < n; i++) begin
      chk(req, int'(head_data), int'(ed[i]));
      chk(req, int'(head_tag), int'(et[i]));
      do_pop_only();
    end
    chk(req, int'(empty), 1);
    en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 count", int'(count), 0);
    rst_n = 1;
    @(negedge clk);

    do_pop_only();
    chk("R3 pop on empty", int'(count), 0);

    for (int i = 0; i < DEPTH; i++) do_push(4'(i));
    chk("R4 full flag", int'(full), 1);
    @(negedge clk); push = 1; push_data = 8'hCC; push_tag = 4'hC;
    @(negedge clk); push = 0;
    chk("R3 push on full", int'(count), DEPTH);
    drain("R2 order");

    for (int rot = 0; rot < DEPTH; rot++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        for (int k = -2; k <= n; k++) begin
          int keep;
          if (k == n && n == DEPTH) continue;
          for (int r = 0; r < rot; r++) begin do_push(4'h0); do_pop_only(); end
          en = 0;
          for (int i = 0; i < n; i++) do_push(4'(i * 3 + 1 + rot));
          chk("R4 count after fill", int'(count), n);
          chk("R4 empty flag", int'(empty), int'(n == 0));
          if (k == -2) begin
            flush(4'h5, 1'b1, n);
            chk("R8 clear all", int'(count), 0);
            en = 0;
          end else if (k == -1 || k == n) begin
            flush(4'hF, 1'b0, n);
            chk("R7 no match keeps count", int'(count), n);
          end else begin
            flush(4'(k * 3 + 1 + rot), 1'b0, n);
            chk("R6 partial flush count", int'(count), k);
            en = k;
          end
          keep = en;
          if (keep < DEPTH) begin
            do_push(4'hA);
            chk("R10 push after flush", int'(count), keep + 1);
          end
          drain((k >= 0 && k < n) ? "R6 R10 kept order" : "R7 R8 contents");
        end
      end
    end

    en = 0;
    do_push(4'h2); do_push(4'h5); do_push(4'h5); do_push(4'h7);
    flush(4'h5, 1'b0, 4);
    chk("R11 duplicate tags", int'(count), 1);
    en = 1; drain("R11 kept");
    do_push(4'h5); do_push(4'h1); do_push(4'h2); do_push(4'h5);
    flush(4'h5, 1'b0, 4);
    chk("R11 oldest match wins", int'(count), 0);
    en = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule